// File: doc/BRIEF.md
# Drive Pulse Command Controller

This block turns coarse command pulses from a host into metered bursts of piezo actuator drive cycles. Once the actuator has finished its startup homing (signalled by `init_done`) and the block is enabled, every command pulse on `drive_in` that survives width qualification adds a fixed budget of drive cycles to a remaining-cycle counter. While cycles remain, `run` and `busy` are high. A downstream waveform generator produces the actual gate waveforms and reports each completed cycle on `cycle_done`.

Width qualification is measured in base ticks (`tick`, a one-clock strobe derived from the drive time base). A command is counted only once its high level and the low level that follows have each lasted at least the qualification length, so short spikes on the command line never start motion. The direction pin selects macro or infinity travel; flipping it during a run, or dropping enable, stops motion at once and discards whatever budget is left.

Top module: `drive_cmd_ctrl`

## Requirements
- R1: After reset `run` and `busy` are low and `dir_out` is 0 (infinity).
- R2: A command whose high level lasts at least 96 ticks, followed by a low level of at least 96 ticks, yields exactly 140 counted `cycle_done` pulses before `busy` falls.
- R3: A command whose high level lasts fewer than 96 ticks is ignored: `busy` stays low.
- R4: A low dip shorter than 96 ticks inside a command does not split it: high, short low, high, long low yields one budget of 140 cycles.
- R5: Budgets of successive accepted commands add up: two commands before any consumption yield 280 cycles.
- R6: `dir_out` is 1 (macro) when `dir_in` is high and 0 (infinity) when `dir_in` is low; it does not change while `run` is high.
- R7: A change of `dir_in` while `busy` is high drops `run` and `busy` within two clocks and clears the remaining budget, so restoring the old direction does not resume motion.
- R8: `en` low drops `run` and `busy` in the same cycle and clears the remaining budget, so re-enabling does not resume motion.
- R9: Commands are ignored while `en` or `init_done` is low.
- R10: The remaining budget saturates at 1023 (2^CNT_W-1, CNT_W=10) rather than wrapping: eight commands before consumption yield 1023 cycles.
- R11: `cycle_done` pulses while `run` is low do not reduce a later budget.
- R12: Widths are counted in `tick` strobes, not clocks: with a tick on every second clock, a 100-clock high level is rejected and a 200-clock high level followed by 200 clocks low is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Base time strobe used to measure command widths |
| en | input | 1 | Block enable; low stops motion and clears the budget |
| init_done | input | 1 | High once startup homing has finished |
| drive_in | input | 1 | Command pulse line (asynchronous, synchronised inside) |
| dir_in | input | 1 | Direction select: 1 macro, 0 infinity |
| cycle_done | input | 1 | One-clock strobe per completed drive cycle |
| run | output | 1 | Drive cycles should be generated |
| dir_out | output | 1 | Direction to apply to the drive waveform |
| busy | output | 1 | Actuator motion in progress |

## Verification
On every cycle the assertions check the budget arithmetic: an accepted command raises the remaining count by exactly one budget (clipped at the ceiling), an abort or loss of enable empties it, an idle block never consumes, the ceiling holds, and the direction is steady during a run. Whether the width qualifier accepts the right edges, which needs long stretches of timed stimulus, is shown only by the bench scenarios: short spikes, dips inside a command, tick-scaled widths, and the cycle count a scoreboard measures between the start of motion and the fall of `busy`.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic {
    DIR_INF   = 1'b0,
    DIR_MACRO = 1'b1
  } dir_e;

  // Next remaining-cycle count: add a burst on accept, take one per
  // consumed cycle, clip at the ceiling instead of wrapping.
  function automatic int unsigned budget_next(
    input int unsigned rem,
    input logic        add,
    input logic        dec,
    input int unsigned burst,
    input int unsigned maxv
  );
    int unsigned s;
    s = rem + (add ? burst : 0);
    if (dec && s != 0) s = s - 1;
    if (s > maxv) s = maxv;
    return s;
  endfunction

endpackage

// File: rtl/dpc_pulse_qual.sv
module dpc_pulse_qual #(
  parameter int QUAL = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  input  logic drive_in,
  output logic accept
);
  localparam int CW = $clog2(QUAL + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL - 1);
  localparam logic [CW-1:0] FULL = CW'(QUAL);

  logic          drv_m, drv_q;
  logic          lvl_q;
  logic [CW-1:0] len_q;
  logic          hi_ok_q;
  logic          same_lvl;
  logic          hi_reach;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_m <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      drv_m <= drive_in;
      drv_q <= drv_m;
    end
  end

  assign same_lvl = (drv_q == lvl_q);
  assign hi_reach = tick && !clear && drv_q && same_lvl && (len_q == LAST);
  assign accept   = tick && !clear && !drv_q && same_lvl && (len_q == LAST) && hi_ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      lvl_q   <= 1'b0;
      len_q   <= '0;
      hi_ok_q <= 1'b0;
    end else if (tick) begin
      if (!same_lvl) begin
        lvl_q <= drv_q;
        len_q <= CW'(1);
      end else if (len_q < FULL) begin
        len_q <= len_q + CW'(1);
      end
      if (hi_reach)    hi_ok_q <= 1'b1;
      else if (accept) hi_ok_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dpc_budget.sv
module dpc_budget #(
  parameter int BURST = 140,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             accept,
  input  logic             dec,
  output logic [CNT_W-1:0] rem_q
);
  import dpc_pkg::*;

  localparam int unsigned MAXV = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] rem_d;

  assign rem_d = CNT_W'(budget_next(32'(rem_q), accept, dec, BURST, MAXV));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) rem_q <= '0;
    else                 rem_q <= rem_d;
  end

endmodule

// File: rtl/dpc_dir_track.sv
module dpc_dir_track (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_in,
  output dpc_pkg::dir_e dir_s,
  output dpc_pkg::dir_e dir_q,
  output logic          mismatch
);
  import dpc_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_s <= DIR_INF;
      dir_q <= DIR_INF;
    end else begin
      dir_s <= dir_in ? DIR_MACRO : DIR_INF;
      dir_q <= dir_s;
    end
  end

  assign mismatch = (dir_s != dir_q);

endmodule

// File: rtl/drive_cmd_ctrl.sv
module drive_cmd_ctrl #(
  parameter int QUAL  = 96,
  parameter int BURST = 140,
  parameter int CNT_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic init_done,
  input  logic drive_in,
  input  logic dir_in,
  input  logic cycle_done,
  output logic run,
  output logic dir_out,
  output logic busy
);
  import dpc_pkg::*;

  logic             en_ok;
  logic             accept;
  logic             dec;
  logic             abort;
  logic             busy_raw;
  logic             mismatch;
  logic             clear;
  logic [CNT_W-1:0] rem_q;
  dir_e             dir_s;
  dir_e             dir_q;

  assign en_ok = en && init_done;

  dpc_pulse_qual #(.QUAL(QUAL)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .clear    (!en_ok),
    .drive_in (drive_in),
    .accept   (accept)
  );

  dpc_dir_track u_dir (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_in   (dir_in),
    .dir_s    (dir_s),
    .dir_q    (dir_q),
    .mismatch (mismatch)
  );

  assign busy_raw = (rem_q != '0);
  assign abort    = busy_raw && en_ok && mismatch;
  assign clear    = !en_ok || abort;
  assign busy     = busy_raw && en_ok && !mismatch;
  assign run      = busy;
  assign dec      = cycle_done && run;
  assign dir_out  = dir_q;

  dpc_budget #(.BURST(BURST), .CNT_W(CNT_W)) u_budget (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .accept (accept && !abort),
    .dec    (dec),
    .rem_q  (rem_q)
  );

endmodule

// File: rtl/drive_cmd_ctrl_chk.sv
module drive_cmd_ctrl_chk #(
  parameter int BURST = 140,
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             en_ok,
  input logic             accept,
  input logic             abort,
  input logic             dec,
  input logic             run,
  input logic             busy,
  input logic             dir_out,
  input logic [CNT_W-1:0] rem_q
);
  import dpc_pkg::*;

  localparam int unsigned MAXV = (1 << CNT_W) - 1;

  p_blocked_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_ok |-> !accept);

  p_burst_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !abort && en_ok) |=>
      (32'(rem_q) == budget_next(32'($past(rem_q)), 1'b1, $past(dec), BURST, MAXV)));

  p_abort_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (rem_q == '0));

  p_enable_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!busy && !run));

  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (rem_q == '0));

  p_ceiling_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rem_q) == MAXV && !dec && !abort && en_ok) |=> (32'(rem_q) == MAXV));

  p_idle_no_consume_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !accept && en_ok && !abort) |=> $stable(rem_q));

  p_dir_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(dir_out));

endmodule

bind drive_cmd_ctrl drive_cmd_ctrl_chk #(.BURST(BURST), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .en_ok   (en_ok),
  .accept  (accept),
  .abort   (abort),
  .dec     (dec),
  .run     (run),
  .busy    (busy),
  .dir_out (dir_out),
  .rem_q   (rem_q)
);

// File: tb/sim_drive_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_drive_cmd_ctrl;
  localparam int BURST = 140;
  localparam int CEIL  = 1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic en = 1'b0;
  logic init_done = 1'b0;
  logic drive_in = 1'b0;
  logic dir_in = 1'b0;
  logic cycle_done = 1'b0;
  logic run, dir_out, busy;

  int n_chk = 0;
  int n_fail = 0;
  int done_cnt = 0;
  int ph = 0;
  bit gen_on = 1'b0;
  bit gen_any = 1'b0;
  bit tick_div = 1'b0;
  bit busy_prev = 1'b0;
  int exp_q[$];

  always #4 clk = ~clk;

  drive_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .init_done(init_done),
    .drive_in(drive_in), .dir_in(dir_in), .cycle_done(cycle_done),
    .run(run), .dir_out(dir_out), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor (scoreboard pop) then cycle producer and tick source
  always @(negedge clk) begin
    if (busy_prev && !busy) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "SB unexpected end of motion", done_cnt, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e < 0) check(done_cnt < BURST, "R7/R8 aborted burst", done_cnt, BURST - 1);
        else       check(done_cnt == e, "R2/R4/R5/R10/R11/R12 burst length", done_cnt, e);
      end
      done_cnt = 0;
    end
    busy_prev = busy;
    cycle_done = 1'b0;
    if ((gen_on && run) || gen_any) begin
      ph++;
      if (ph >= 3) begin
        ph = 0;
        cycle_done = 1'b1;
        if (run) done_cnt++;
      end
    end
    tick = tick_div ? ~tick : 1'b1;
  end

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    @(negedge clk); drive_in = 1'b1;
    wait_clks(hi);
    drive_in = 1'b0;
    wait_clks(lo);
  endtask

  task automatic wait_drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 20000) begin
      @(negedge clk); t++;
    end
    check(exp_q.size() == 0, "SB drain", exp_q.size(), 0);
    wait_clks(2);
  endtask

  initial begin
    #1_600_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(1);
    // R1 reset state
    check(!run, "R1 run", run, 0);
    check(!busy, "R1 busy", busy, 0);
    check(!dir_out, "R1 dir_out", dir_out, 0);

    // R6 direction mapping while idle
    dir_in = 1'b1; wait_clks(4);
    check(dir_out == 1'b1, "R6 macro", dir_out, 1);
    dir_in = 1'b0; wait_clks(4);
    check(dir_out == 1'b0, "R6 infinity", dir_out, 0);

    // R9 commands ignored while not initialised or disabled
    en = 1'b1; init_done = 1'b0;
    pulse(100, 100);
    check(!busy, "R9 before init_done", busy, 0);
    init_done = 1'b1; en = 1'b0;
    pulse(100, 100);
    check(!busy, "R9 while disabled", busy, 0);
    en = 1'b1; wait_clks(4);

    // R11 cycle_done while idle does not eat into later budget
    gen_any = 1'b1; wait_clks(60); gen_any = 1'b0;
    check(!busy, "R11 idle", busy, 0);

    // R2 single command, R11 budget intact
    gen_on = 1'b1;
    exp_q.push_back(BURST);
    pulse(100, 100);
    wait_drain();

    // R3 short high rejected
    pulse(90, 100);
    wait_clks(10);
    check(!busy, "R3 short pulse", busy, 0);

    // R4 dip inside a command
    exp_q.push_back(BURST);
    pulse(100, 50);
    pulse(100, 100);
    wait_drain();

    // R5 accumulation
    gen_on = 1'b0;
    exp_q.push_back(2 * BURST);
    pulse(100, 100);
    pulse(100, 100);
    check(busy, "R5 busy held", busy, 1);
    gen_on = 1'b1;
    wait_drain();

    // R10 saturation
    gen_on = 1'b0;
    exp_q.push_back(CEIL);
    for (int k = 0; k < 8; k++) pulse(100, 100);
    gen_on = 1'b1;
    wait_drain();

    // R12 widths counted in ticks
    tick_div = 1'b1;
    pulse(100, 200);
    check(!busy, "R12 100 clocks rejected", busy, 0);
    exp_q.push_back(BURST);
    pulse(200, 200);
    wait_drain();
    tick_div = 1'b0;

    // R7 direction change aborts and clears
    exp_q.push_back(-1);
    pulse(100, 100);
    wait_clks(30);
    check(busy, "R7 running before flip", busy, 1);
    dir_in = 1'b1;
    wait_clks(2);
    check(!busy && !run, "R7 stop after flip", busy, 0);
    dir_in = 1'b0;
    wait_clks(50);
    check(!busy, "R7 budget cleared", busy, 0);

    // R8 enable low stops at once and clears
    exp_q.push_back(-1);
    pulse(100, 100);
    wait_clks(30);
    #1 en = 1'b0;
    #1 check(!busy && !run, "R8 immediate stop", busy, 0);
    wait_clks(5);
    en = 1'b1;
    wait_clks(50);
    check(!busy, "R8 budget cleared", busy, 0);
    check(exp_q.size() == 0, "SB all popped", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule